// File: doc/BRIEF.md
# Fine-Rate Time-of-Day Counter with Pulse-Per-Second Output

This block keeps a precision time-of-day value made of a seconds field and a nanoseconds field. It runs from a fixed reference clock, and its rate is trimmed by a 32-bit fractional accumulator. On every reference cycle the programmed rate word is added to the accumulator. Each time that addition carries out, the nanoseconds field moves forward by a programmable step. The nanoseconds field wraps in decimal at one billion, and the excess carries into the seconds field. Every seconds carry starts a pulse on the pulse-per-second pin, whose width is programmable.

Software sets the nominal step from the reference period, for example 20 ns at 50 MHz. It then trims the rate word from a measured pulse period: new word = old word × measured period / 1 s. Full scale (0xFFFFFFFF) is the fastest rate for a given step. If the correction would need a word above full scale, the step is raised first and the word is recomputed below full scale. A load strobe sets the time directly.

Top module: `ptp_fine_clock`

## Requirements
- R1: After reset, time reads seconds 0 and nanoseconds 0, the PPS pin is low, the enable bit is clear, and the rate word, the step and the pulse width are all zero.
- R2: While the enable bit (control register bit 0) is clear, the accumulator and the time fields hold their values and no PPS pulse starts.
- R3: While enabled, each reference cycle adds the rate word to the 32-bit accumulator modulo 2^32. In a cycle whose addition carries out of bit 31, the nanoseconds field grows by the step at that same edge. In any other cycle the nanoseconds field is unchanged.
- R4: When nanoseconds plus the step reaches 1,000,000,000 or more, nanoseconds becomes the sum minus 1,000,000,000, keeping the excess, and seconds grows by exactly one.
- R5: The PPS pin goes high at the edge where seconds increments and stays high for W cycles. W is control register bits [23:8]; a value of 0 counts as 1. A new seconds carry during a pulse restarts the count.
- R6: A register write takes effect for the advance at the next clock edge. The accumulator keeps its residue across writes to the rate word and the step.
- R7: A load strobe sets seconds and nanoseconds to the load inputs and clears the accumulator at that edge, whether or not the counter is enabled. It takes priority over an advance in the same cycle, and it never starts a PPS pulse.
- R8: Register select 0 writes the rate word, 1 writes the step (data bits [7:0]), and 2 writes the control register. A write with select 3 changes nothing.
- R9: A step of 40 with rate word 0x80000000 yields the same average nanosecond rate as a step of 20 with rate word 0xFFFFFFFF, within one step over 1000 cycles from a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 rate word, 1 step, 2 control, 3 none |
| cfg_wdata | input | 32 | Register write data |
| ld_stb | input | 1 | Time load strobe |
| ld_sec | input | SEC_W (48) | Seconds value to load |
| ld_ns | input | NS_W (30) | Nanoseconds value to load |
| tod_sec | output | SEC_W (48) | Current seconds |
| tod_ns | output | NS_W (30) | Current nanoseconds |
| pps_out | output | 1 | Pulse-per-second pin |

## Verification
Several pairs of functions can land on the same edge: a decimal wrap and a load strobe, a wrap and a register write, and a new seconds carry and a pulse that is still running. The bench provokes the first pair by loading a nanoseconds value a few steps short of the wrap point and then strobing a second load exactly as the next step would wrap. Load must win and no pulse may start. It provokes the retrigger by loading near the wrap twice while a long pulse is still active. A behavioural model compares seconds, nanoseconds and the pin on every cycle, so the edge on which each event lands is judged directly.

// File: rtl/ptp_fine_pkg.sv
package ptp_fine_pkg;

  localparam int unsigned NS_PER_SEC  = 32'd1_000_000_000;
  localparam int          CTRL_EN_BIT = 0;
  localparam int          CTRL_PW_LSB = 8;

  typedef enum logic [1:0] {
    SEL_RATE = 2'd0,
    SEL_STEP = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

endpackage

// File: rtl/ptp_cfg_regs.sv
module ptp_cfg_regs
  import ptp_fine_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int INC_W = 8,
  parameter int PW_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [ACC_W-1:0] wdata,
  output logic [ACC_W-1:0] rate_q,
  output logic [INC_W-1:0] step_q,
  output logic             en_q,
  output logic [PW_W-1:0]  pw_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= '0;
      step_q <= '0;
      en_q   <= 1'b0;
      pw_q   <= '0;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        SEL_RATE: rate_q <= wdata;
        SEL_STEP: step_q <= wdata[INC_W-1:0];
        SEL_CTRL: begin
          en_q <= wdata[CTRL_EN_BIT];
          pw_q <= wdata[CTRL_PW_LSB +: PW_W];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ptp_rate_accum.sv
module ptp_rate_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic [ACC_W-1:0] rate,
  output logic             carry
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum   = {1'b0, acc_q} + {1'b0, rate};
  assign carry = en & sum[ACC_W];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
    end else if (en) begin
      acc_q <= sum[ACC_W-1:0];
    end
  end

  // a carry can only be produced by a nonzero rate word
  AST_CARRY_NEEDS_RATE: assert property (@(posedge clk) disable iff (rst)
    carry |-> (rate != '0)); // R3

endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_fine_pkg::*;
#(
  parameter int SEC_W = 48,
  parameter int NS_W  = 30,
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             step,
  input  logic [INC_W-1:0] inc,
  input  logic             ld,
  input  logic [SEC_W-1:0] ld_sec,
  input  logic [NS_W-1:0]  ld_ns,
  output logic [SEC_W-1:0] sec_q,
  output logic [NS_W-1:0]  ns_q,
  output logic             wrap
);

  localparam logic [NS_W:0] NS_LIM = (NS_W+1)'(NS_PER_SEC);

  logic [NS_W:0] ns_sum;
  logic [NS_W:0] ns_wrapped;

  assign ns_sum     = {1'b0, ns_q} + (NS_W+1)'(inc);
  assign ns_wrapped = ns_sum - NS_LIM;
  assign wrap       = step && !ld && (ns_sum >= NS_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else if (ld) begin
      sec_q <= ld_sec;
      ns_q  <= ld_ns;
    end else if (step) begin
      if (wrap) begin
        ns_q  <= ns_wrapped[NS_W-1:0];
        sec_q <= sec_q + SEC_W'(1);
      end else begin
        ns_q  <= ns_sum[NS_W-1:0];
      end
    end
  end

  AST_NS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (!ld && ({1'b0, ns_q} < NS_LIM)) |=> ({1'b0, ns_q} < NS_LIM)); // R4

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en && !ld) |=> ($stable(ns_q) && $stable(sec_q))); // R2

  AST_NO_STEP_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
    (!step && !ld) |=> $stable(ns_q)); // R3

  AST_SEC_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    !ld |=> ((sec_q == $past(sec_q)) || (sec_q == $past(sec_q) + SEC_W'(1)))); // R4

endmodule

// File: rtl/ptp_pps_gen.sv
module ptp_pps_gen #(
  parameter int PW_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [PW_W-1:0] width,
  output logic            pps_q
);

  logic [PW_W-1:0] rem_q;
  logic [PW_W-1:0] width_eff;

  assign width_eff = (width == '0) ? PW_W'(1) : width;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      pps_q <= 1'b0;
    end else if (tick) begin
      rem_q <= width_eff - PW_W'(1);
      pps_q <= 1'b1;
    end else if (rem_q != '0) begin
      rem_q <= rem_q - PW_W'(1);
      pps_q <= 1'b1;
    end else begin
      pps_q <= 1'b0;
    end
  end

  AST_PPS_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (rst)
    (!tick && !pps_q) |=> !pps_q); // R5

endmodule

// File: rtl/ptp_fine_clock.sv
module ptp_fine_clock
  import ptp_fine_pkg::*;
#(
  parameter int SEC_W = 48,
  parameter int NS_W  = 30,
  parameter int ACC_W = 32,
  parameter int INC_W = 8,
  parameter int PW_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [ACC_W-1:0] cfg_wdata,
  input  logic             ld_stb,
  input  logic [SEC_W-1:0] ld_sec,
  input  logic [NS_W-1:0]  ld_ns,
  output logic [SEC_W-1:0] tod_sec,
  output logic [NS_W-1:0]  tod_ns,
  output logic             pps_out
);

  logic [ACC_W-1:0] rate;
  logic [INC_W-1:0] step_ns;
  logic             run_en;
  logic [PW_W-1:0]  pulse_w;
  logic             acc_carry;
  logic             sec_wrap;

  ptp_cfg_regs #(.ACC_W(ACC_W), .INC_W(INC_W), .PW_W(PW_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .sel    (cfg_sel),
    .wdata  (cfg_wdata),
    .rate_q (rate),
    .step_q (step_ns),
    .en_q   (run_en),
    .pw_q   (pulse_w)
  );

  ptp_rate_accum #(.ACC_W(ACC_W)) u_accum (
    .clk   (clk),
    .rst   (rst),
    .en    (run_en),
    .clr   (ld_stb),
    .rate  (rate),
    .carry (acc_carry)
  );

  ptp_tod_counter #(.SEC_W(SEC_W), .NS_W(NS_W), .INC_W(INC_W)) u_tod (
    .clk    (clk),
    .rst    (rst),
    .en     (run_en),
    .step   (acc_carry),
    .inc    (step_ns),
    .ld     (ld_stb),
    .ld_sec (ld_sec),
    .ld_ns  (ld_ns),
    .sec_q  (tod_sec),
    .ns_q   (tod_ns),
    .wrap   (sec_wrap)
  );

  ptp_pps_gen #(.PW_W(PW_W)) u_pps (
    .clk   (clk),
    .rst   (rst),
    .tick  (sec_wrap),
    .width (pulse_w),
    .pps_q (pps_out)
  );

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    ld_stb |=> ((tod_sec == $past(ld_sec)) && (tod_ns == $past(ld_ns)))); // R7

  AST_SEC_CARRY_PULSES: assert property (@(posedge clk) disable iff (rst)
    !ld_stb |=> ((tod_sec != $past(tod_sec)) -> pps_out)); // R5

endmodule

// File: tb/ptp_fine_clock_bench.sv
module ptp_fine_clock_bench;

  localparam int SEC_W = 48;
  localparam int NS_W  = 30;
  localparam longint TWO32 = 64'h1_0000_0000;
  localparam longint BILLION = 64'd1_000_000_000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_sel = '0;
  logic [31:0]      cfg_wdata = '0;
  logic             ld_stb = 1'b0;
  logic [SEC_W-1:0] ld_sec = '0;
  logic [NS_W-1:0]  ld_ns = '0;
  logic [SEC_W-1:0] tod_sec;
  logic [NS_W-1:0]  tod_ns;
  logic             pps_out;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  longint m_acc, m_rate, m_step, m_pw, m_sec, m_ns, m_rem;
  bit     m_en, m_pps;

  always #4 clk = ~clk;

  ptp_fine_clock u_ptp_fine_clock (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ld_stb(ld_stb), .ld_sec(ld_sec), .ld_ns(ld_ns),
    .tod_sec(tod_sec), .tod_ns(tod_ns), .pps_out(pps_out)
  );

  always @(posedge clk) begin
    bit tick;
    longint s;
    tick = 1'b0;
    if (rst) begin
      m_acc = 0; m_rate = 0; m_step = 0; m_pw = 0; m_sec = 0; m_ns = 0;
      m_rem = 0; m_en = 1'b0; m_pps = 1'b0;
    end else begin
      if (ld_stb) begin
        m_sec = longint'(ld_sec); m_ns = longint'(ld_ns); m_acc = 0;
      end else if (m_en) begin
        s = m_acc + m_rate;
        if (s >= TWO32) begin
          s = s - TWO32;
          m_ns = m_ns + m_step;
          if (m_ns >= BILLION) begin
            m_ns = m_ns - BILLION;
            m_sec = m_sec + 1;
            tick = 1'b1;
          end
        end
        m_acc = s;
      end
      if (tick) begin
        m_rem = ((m_pw == 0) ? 1 : m_pw) - 1;
        m_pps = 1'b1;
      end else if (m_rem > 0) begin
        m_rem = m_rem - 1;
      end else begin
        m_pps = 1'b0;
      end
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: m_rate = longint'(cfg_wdata);
          2'd1: m_step = longint'(cfg_wdata[7:0]);
          2'd2: begin m_en = cfg_wdata[0]; m_pw = longint'(cfg_wdata[23:8]); end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_chk++;
      if (longint'(tod_sec) != m_sec || longint'(tod_ns) != m_ns) begin
        n_bad++;
        $display("FAIL %s time: got sec=%0d ns=%0d, expected sec=%0d ns=%0d",
                 cur_req, tod_sec, tod_ns, m_sec, m_ns);
      end
      n_chk++;
      if (pps_out != m_pps) begin
        n_bad++;
        $display("FAIL %s pps: got %0b, expected %0b", cur_req, pps_out, m_pps);
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load(input longint s, input longint ns);
    @(negedge clk);
    ld_stb = 1'b1; ld_sec = SEC_W'(s); ld_ns = NS_W'(ns);
    @(negedge clk);
    ld_stb = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic direct(input string req, input bit ok, input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d, expected %0d", req, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    longint a_ns;
    longint b_ns;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    direct("R1", tod_sec == '0 && tod_ns == '0, longint'(tod_ns), 0);
    direct("R1", pps_out == 1'b0, longint'(pps_out), 0);

    cur_req = "R2";
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'd20);
    run(20);
    direct("R2", tod_ns == '0, longint'(tod_ns), 0);

    cur_req = "R7";
    load(5, 999_999_000);
    run(10);
    direct("R7", tod_sec == 48'd5 && tod_ns == 30'd999_999_000, longint'(tod_ns), 999_999_000);

    cur_req = "R3";
    wr(2'd2, 32'h0000_0301);
    run(30);
    cur_req = "R4";
    run(40);
    direct("R4", tod_sec == 48'd6, longint'(tod_sec), 6);
    cur_req = "R5";
    run(20);

    cur_req = "R6";
    wr(2'd0, 32'h8000_0000);
    run(7);
    wr(2'd1, 32'd21);
    run(40);

    cur_req = "R8";
    wr(2'd3, 32'h0000_0000);
    run(20);
    direct("R8", tod_ns != 30'd0, longint'(tod_ns), 1);

    cur_req = "R7";
    wr(2'd0, 32'hFFFF_FFFF);
    load(100, 999_999_950);
    run(2);
    load(200, 999_999_990);
    run(5);

    cur_req = "R5";
    wr(2'd1, 32'd255);
    wr(2'd2, 32'h0000_0001);
    load(300, 999_999_700);
    run(8);
    wr(2'd2, 32'h0000_2801);
    load(301, 999_999_700);
    run(4);
    load(302, 999_999_600);
    run(60);

    cur_req = "R9";
    wr(2'd1, 32'd20);
    wr(2'd0, 32'hFFFF_FFFF);
    load(0, 0);
    run(999);
    a_ns = longint'(tod_ns);
    wr(2'd1, 32'd40);
    wr(2'd0, 32'h8000_0000);
    load(0, 0);
    run(999);
    b_ns = longint'(tod_ns);
    direct("R9", (a_ns - b_ns <= 40) && (b_ns - a_ns <= 40), b_ns, a_ns);

    cur_req = "R2";
    wr(2'd2, 32'h0000_0000);
    run(30);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule